// File: doc/BRIEF.md
# Double-Buffered Multi-Mode Serial Port

This block is a full-duplex serial port for a small 8-bit controller. Software sees two byte-wide locations. Address 0 is a control/status register. Address 1 is the data location. A write to the data location loads the transmit shift register and starts a frame. A read from the same location returns a separate receive holding register, so the transmit path and the receive path never share storage.

A 2-bit mode field selects one of four framings that share one datapath:
- a synchronous mode that shifts a byte out against a port-driven shift clock;
- a 10-bit asynchronous frame timed by an external baud tick;
- an 11-bit asynchronous frame at a fixed fraction of the system clock;
- an 11-bit asynchronous frame timed by the external baud tick.

The external tick runs at 16 times the bit rate, and the timer that produces it sits outside this block. The receiver is double-buffered. A second byte may arrive while the first still waits in the holding register. Two flags, transmit-done and receive-ready, are set by hardware, cleared by software, and drive two interrupt outputs.

Top module: `serial_port`

## Requirements
- R1: After reset, txd and sclk are high, irq_tx and irq_rx are low, and the control register reads 0x00.
- R2: The control register is at reg_addr 0 and the data location at reg_addr 1. The control bits are: [1:0] mode (0 synchronous, 1 ten-bit on baud tick, 2 eleven-bit fixed rate, 3 eleven-bit on baud tick), [2] receive enable, [3] transmit ninth bit, [4] received ninth bit (read-only), [5] transmit-done flag, [6] receive-ready flag, [7] overrun flag. Bits [3:0] read back as written.
- R3: When software writes the control register, a 0 in a flag bit clears that flag and a 1 leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R4: Mode 1 sends a 10-bit frame: a low start bit, the 8 data bits LSB first, then a high stop bit. Each bit lasts 16 baud_tick pulses.
- R5: Modes 2 and 3 send an 11-bit frame: start, 8 data bits LSB first, control bit [3], then stop. In mode 3 each bit lasts 16 baud ticks. In mode 2 each bit lasts 16*FIX_DIV clock cycles, and baud_tick has no effect.
- R6: Mode 0 sends 8 data bits LSB first on txd. sclk idles high and toggles every SYNC_DIV cycles, and txd is stable at each of the 8 rising edges of sclk.
- R7: The transmit-done flag, mirrored on irq_tx, sets after the last bit of a frame completes.
- R8: A write to the data location while a frame is being sent is ignored.
- R9: In modes 1 to 3 with receive enable set, a frame on rxd is decoded by a majority of three samples taken at oversample ticks 7, 8 and 9 of each bit. The byte goes to the holding register, the receive-ready flag sets, and control bit [4] takes the ninth bit (in mode 1, the stop bit).
- R10: A low pulse on rxd shorter than half a bit is rejected as a glitch and sets no flag.
- R11: A new frame may be received while the previous byte is still unread. If the holding register is read and the flag cleared before the new frame ends, the new byte is stored with no overrun.
- R12: When a frame ends while receive-ready is still set, the holding register keeps the old byte and the overrun flag sets.
- R13: Transmit and receive run at the same time without disturbing each other.
- R14: With receive enable clear, rxd activity sets no flag and leaves the holding register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | External 16x bit-rate tick, one cycle wide |
| reg_addr | input | 1 | 0 = control/status, 1 = data |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line (also the data line in mode 0) |
| sclk | output | 1 | Shift clock for mode 0, high otherwise |
| irq_tx | output | 1 | Transmit-done flag |
| irq_rx | output | 1 | Receive-ready flag |

## Verification
Timing:
- **Transmit.** txd falls one clock after the data write. The bench finds the start edge on the line and samples each later bit in the middle of its bit period (64 clocks on the baud tick, 32 in fixed-rate mode). This leaves several clocks of slack, so the exact cycle of the load does not matter.
- **Synchronous mode.** Bits are taken at each observed rising edge of sclk.
- **Receive.** The flags and the holding register settle within a few clocks after the middle of the stop bit. The bench reads them only after the whole stop bit has been driven.
- **Transmit flag.** The bench polls for the transmit flag within a bounded window after the last bit.

// File: rtl/sp_pkg.sv
package sp_pkg;
   typedef enum logic [1:0] {
      MODE_SYNC    = 2'd0,
      MODE_A10     = 2'd1,
      MODE_A11_FIX = 2'd2,
      MODE_A11_TMR = 2'd3
   } sp_mode_e;

   localparam int CTL_RXEN = 2;
   localparam int CTL_TX9  = 3;
   localparam int CTL_RX9  = 4;
   localparam int CTL_TXF  = 5;
   localparam int CTL_RXF  = 6;
   localparam int CTL_OVR  = 7;

   // index of the last bit of an asynchronous frame
   function automatic logic [3:0] frame_last(sp_mode_e m);
      return (m == MODE_A10) ? 4'd9 : 4'd10;
   endfunction
endpackage

// File: rtl/sp_tick.sv
module sp_tick #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   initial assert (DIV >= 1) else $error("sp_tick: DIV must be at least 1");

   generate
      if (DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         localparam int W = $clog2(DIV);
         localparam logic [W-1:0] LIM = W'(DIV - 1);
         logic [W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (cnt == LIM) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == LIM);
      end
   endgenerate
endmodule

// File: rtl/sp_tx.sv
module sp_tx
   import sp_pkg::*;
#(
   parameter int OS       = 16,
   parameter int SYNC_DIV = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  sp_mode_e mode,
   input  logic     os_tick,
   input  logic     load,
   input  logic [7:0] din,
   input  logic     bit9,
   output logic     txd,
   output logic     sclk,
   output logic     busy,
   output logic     done
);
   localparam int OSW = $clog2(OS);
   localparam int SDW = $clog2(SYNC_DIV);
   localparam logic [OSW-1:0] OS_LIM = OSW'(OS - 1);
   localparam logic [SDW-1:0] SD_LIM = SDW'(SYNC_DIV - 1);

   initial assert (SYNC_DIV >= 2) else $error("sp_tx: SYNC_DIV must be at least 2");
   initial assert (OS >= 8 && (OS & (OS - 1)) == 0) else $error("sp_tx: OS must be a power of two >= 8");

   logic [10:0]    sh;
   logic [3:0]     bit_cnt;
   logic [OSW-1:0] os_cnt;
   logic [SDW-1:0] div_cnt;
   logic           sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '1; bit_cnt <= '0; os_cnt <= '0; div_cnt <= '0;
         sclk_q <= 1'b1; busy <= 1'b0; done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load && !busy) begin
            busy <= 1'b1; bit_cnt <= '0; os_cnt <= '0; div_cnt <= '0; sclk_q <= 1'b1;
            if (mode == MODE_SYNC) sh <= {3'b111, din};
            else                   sh <= {1'b1, (mode == MODE_A10) ? 1'b1 : bit9, din, 1'b0};
         end else if (busy) begin
            if (mode == MODE_SYNC) begin
               if (div_cnt == SD_LIM) begin
                  div_cnt <= '0;
                  if (sclk_q) begin
                     if (bit_cnt == 4'd8) begin
                        busy <= 1'b0; done <= 1'b1;
                     end else begin
                        sclk_q <= 1'b0;
                        if (bit_cnt != 4'd0) sh <= {1'b1, sh[10:1]};
                     end
                  end else begin
                     sclk_q  <= 1'b1;
                     bit_cnt <= bit_cnt + 4'd1;
                  end
               end else begin
                  div_cnt <= div_cnt + 1'b1;
               end
            end else if (os_tick) begin
               if (os_cnt == OS_LIM) begin
                  os_cnt <= '0;
                  sh     <= {1'b1, sh[10:1]};
                  if (bit_cnt == frame_last(mode)) begin
                     busy <= 1'b0; done <= 1'b1;
                  end else begin
                     bit_cnt <= bit_cnt + 4'd1;
                  end
               end else begin
                  os_cnt <= os_cnt + 1'b1;
               end
            end
         end
      end
   end

   assign txd  = busy ? sh[0] : 1'b1;
   assign sclk = sclk_q;

   // R4
   bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (bit_cnt <= 4'd10));
   // R6
   sync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_q) |-> $stable(sh));
endmodule

// File: rtl/sp_rx.sv
module sp_rx #(
   parameter int OS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       eleven,
   input  logic       os_tick,
   input  logic       rxd,
   output logic       done,
   output logic [7:0] data,
   output logic       bit9
);
   localparam int OSW = $clog2(OS);
   localparam int MID = OS / 2;
   localparam logic [OSW-1:0] S0     = OSW'(MID - 1);
   localparam logic [OSW-1:0] S1     = OSW'(MID);
   localparam logic [OSW-1:0] S2     = OSW'(MID + 1);
   localparam logic [OSW-1:0] OS_LIM = OSW'(OS - 1);

   logic [1:0]     sync_q;
   logic           rxs, active, maj;
   logic [3:0]     idx, widx, last;
   logic [OSW-1:0] cnt;
   logic [1:0]     v;
   logic [8:0]     rsh;

   assign rxs  = sync_q[1];
   assign maj  = (v[0] & v[1]) | (v[0] & rxs) | (v[1] & rxs);
   assign last = eleven ? 4'd10 : 4'd9;
   assign widx = idx - 4'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= 2'b11; active <= 1'b0; idx <= '0; cnt <= '0; v <= '0;
         rsh <= '0; done <= 1'b0; data <= '0; bit9 <= 1'b0;
      end else begin
         sync_q <= {sync_q[0], rxd};
         done   <= 1'b0;
         if (!en) begin
            active <= 1'b0;
         end else if (os_tick) begin
            if (!active) begin
               if (!rxs) begin
                  active <= 1'b1; idx <= '0; cnt <= OSW'(1);
               end
            end else begin
               if (cnt == S0) v[0] <= rxs;
               if (cnt == S1) v[1] <= rxs;
               if (cnt == S2) begin
                  if (idx == 4'd0) begin
                     if (maj) active <= 1'b0;
                  end else if (idx == last) begin
                     done   <= 1'b1;
                     active <= 1'b0;
                     data   <= rsh[7:0];
                     bit9   <= eleven ? rsh[8] : maj;
                  end else begin
                     rsh[widx] <= maj;
                  end
               end
               if (cnt == OS_LIM) begin
                  cnt <= '0;
                  idx <= idx + 4'd1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   end

   // R9
   rx_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(en));
endmodule

// File: rtl/serial_port.sv
module serial_port
   import sp_pkg::*;
#(
   parameter int OS       = 16,
   parameter int FIX_DIV  = 2,
   parameter int SYNC_DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick,
   input  logic       reg_addr,
   input  logic       reg_wr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       rxd,
   output logic       txd,
   output logic       sclk,
   output logic       irq_tx,
   output logic       irq_rx
);
   sp_mode_e   mode;
   logic       rx_en, tx9, rx9, f_tx, f_rx, f_ovr;
   logic [7:0] hold;
   logic       fix_tick, os_tick, ctl_wr, tx_busy, tx_done;
   logic       rx_done, rx_bit9, f_rx_kept, rx_on;
   logic [7:0] rx_data;

   assign ctl_wr    = reg_wr && !reg_addr;
   assign os_tick   = (mode == MODE_A11_FIX) ? fix_tick : baud_tick;
   assign rx_on     = rx_en && (mode != MODE_SYNC);
   assign f_rx_kept = f_rx && !(ctl_wr && !reg_wdata[CTL_RXF]);

   sp_tick #(.DIV(FIX_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(fix_tick));

   sp_tx #(.OS(OS), .SYNC_DIV(SYNC_DIV)) u_tx (
      .clk(clk), .rst_n(rst_n), .mode(mode), .os_tick(os_tick),
      .load(reg_wr && reg_addr), .din(reg_wdata), .bit9(tx9),
      .txd(txd), .sclk(sclk), .busy(tx_busy), .done(tx_done));

   sp_rx #(.OS(OS)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(rx_on), .eleven(mode[1]), .os_tick(os_tick),
      .rxd(rxd), .done(rx_done), .data(rx_data), .bit9(rx_bit9));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= MODE_SYNC; rx_en <= 1'b0; tx9 <= 1'b0; rx9 <= 1'b0;
         f_tx <= 1'b0; f_rx <= 1'b0; f_ovr <= 1'b0; hold <= '0;
      end else begin
         if (ctl_wr) begin
            mode  <= sp_mode_e'(reg_wdata[1:0]);
            rx_en <= reg_wdata[CTL_RXEN];
            tx9   <= reg_wdata[CTL_TX9];
         end
         f_tx <= (f_tx && !(ctl_wr && !reg_wdata[CTL_TXF])) || tx_done;
         f_rx <= f_rx_kept || rx_done;
         if (rx_done && f_rx_kept) begin
            f_ovr <= 1'b1;
         end else begin
            f_ovr <= f_ovr && !(ctl_wr && !reg_wdata[CTL_OVR]);
         end
         if (rx_done && !f_rx_kept) begin
            hold <= rx_data;
            rx9  <= rx_bit9;
         end
      end
   end

   assign reg_rdata = reg_addr ? hold : {f_ovr, f_rx, f_tx, rx9, tx9, rx_en, mode};
   assign irq_tx    = f_tx;
   assign irq_rx    = f_rx;

   // R12
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && f_rx && !ctl_wr) |=> ($stable(hold) && f_ovr));
   // R7
   tx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_tx) |-> !tx_busy);
   // R14
   rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !$past(rx_en)) |=> !rx_done);
endmodule

// File: tb/tb_serial_port.sv
module tb_serial_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       reg_addr = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       rxd = 1'b1;
   logic       txd, sclk, irq_tx, irq_rx;

   int checks = 0;
   int errors = 0;
   int tdiv = 0;
   logic [1:0] cur_mode = 2'd0;
   logic       cur_rxen = 1'b0;
   logic       cur_tx9 = 1'b0;

   serial_port dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rxd(rxd), .txd(txd), .sclk(sclk), .irq_tx(irq_tx), .irq_rx(irq_rx));

   always #4 clk = ~clk;

   always @(posedge clk) begin
      tdiv      <= (tdiv == 3) ? 0 : tdiv + 1;
      baud_tick <= (tdiv == 3);
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   function automatic int bitc(input logic [1:0] m);
      return (m == 2'd2) ? 32 : 64;
   endfunction

   function automatic logic [10:0] exp_frame(input logic [1:0] m, input logic [7:0] d, input logic b9);
      return (m == 2'd1) ? {2'b11, d, 1'b0} : {1'b1, b9, d, 1'b0};
   endfunction

   task automatic set_ctl(input logic [1:0] m, input logic re, input logic t9);
      cur_mode = m; cur_rxen = re; cur_tx9 = t9;
      wr(1'b0, {4'b0000, t9, re, m});
   endtask

   task automatic clr_flags();
      wr(1'b0, {4'b0000, cur_tx9, cur_rxen, cur_mode});
   endtask

   task automatic wait_irq_tx();
      for (int w = 0; w < 300 && !irq_tx; w++) @(negedge clk);
   endtask

   task automatic capture(output logic [10:0] bits);
      int n;
      int bc;
      n = (cur_mode == 2'd1) ? 10 : 11;
      bc = bitc(cur_mode);
      bits = '1;
      for (int w = 0; w < 2000 && txd !== 1'b0; w++) @(negedge clk);
      repeat (bc / 2) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         bits[i] = txd;
         if (i != n - 1) repeat (bc) @(negedge clk);
      end
      wait_irq_tx();
   endtask

   task automatic send_rx(input logic [7:0] d, input logic b9);
      int n;
      int bc;
      logic [10:0] f;
      n = (cur_mode == 2'd1) ? 10 : 11;
      bc = bitc(cur_mode);
      f = exp_frame(cur_mode, d, b9);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rxd = f[i];
         repeat (bc - 1) @(negedge clk);
      end
      rxd = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic tx_check(input logic [7:0] d, input string req);
      logic [10:0] got;
      logic [10:0] exp;
      exp = exp_frame(cur_mode, d, cur_tx9);
      wr(1'b1, d);
      capture(got);
      chk(got == exp, req, got, exp);
      chk(irq_tx == 1'b1, "R7", irq_tx, 1);
      clr_flags();
   endtask

   task automatic rx_check(input logic [7:0] d, input logic b9, input string req);
      logic [7:0] v;
      logic       e9;
      send_rx(d, b9);
      chk(irq_rx == 1'b1, req, irq_rx, 1);
      rd(1'b1, v);
      chk(v == d, req, v, d);
      e9 = (cur_mode == 2'd1) ? 1'b1 : b9;
      rd(1'b0, v);
      chk(v[4] == e9, req, v[4], e9);
      clr_flags();
   endtask

   initial begin
      logic [7:0] v;
      logic [7:0] a;
      logic [7:0] b;
      logic [10:0] got;
      int unsigned seed;
      seed = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(1'b0, v);
      chk(v == 8'h00, "R1", v, 0);
      chk(txd == 1'b1 && sclk == 1'b1, "R1", {txd, sclk}, 3);
      chk(irq_tx == 1'b0 && irq_rx == 1'b0, "R1", {irq_tx, irq_rx}, 0);

      // R2 control readback
      set_ctl(2'd1, 1'b1, 1'b1);
      rd(1'b0, v);
      chk(v == 8'h0D, "R2", v, 8'h0D);
      set_ctl(2'd1, 1'b0, 1'b0);

      // R4 ten-bit transmit, directed then random
      tx_check(8'hA5, "R4");
      tx_check(8'h00, "R4");
      tx_check(8'hFF, "R4");
      for (int k = 0; k < 3; k++) tx_check(8'($urandom), "R4");

      // R3 flag write semantics
      wr(1'b1, 8'h3C);
      capture(got);
      wr(1'b0, {4'b0010, cur_tx9, cur_rxen, cur_mode});
      chk(irq_tx == 1'b1, "R3", irq_tx, 1);
      rd(1'b0, v);
      chk(v[5] == 1'b1, "R3", v[5], 1);
      clr_flags();
      chk(irq_tx == 1'b0, "R3", irq_tx, 0);

      // R8 write while busy ignored
      wr(1'b1, 8'h5A);
      repeat (20) @(negedge clk);
      wr(1'b1, 8'hC3);
      capture(got);
      chk(got == exp_frame(2'd1, 8'h5A, 1'b0), "R8", got, exp_frame(2'd1, 8'h5A, 1'b0));
      clr_flags();

      // R5 eleven-bit modes
      for (int k = 0; k < 4; k++) begin
         set_ctl((k % 2 == 0) ? 2'd3 : 2'd2, 1'b0, 1'($urandom));
         tx_check(8'($urandom), "R5");
      end

      // R6 synchronous mode
      set_ctl(2'd0, 1'b0, 1'b0);
      for (int k = 0; k < 3; k++) begin
         logic [7:0] d;
         logic [7:0] cap;
         logic prev;
         d = (k == 0) ? 8'h96 : 8'($urandom);
         cap = '0;
         wr(1'b1, d);
         prev = sclk;
         for (int i = 0; i < 8; i++) begin
            for (int w = 0; w < 100; w++) begin
               @(negedge clk);
               if (sclk && !prev) begin prev = sclk; break; end
               prev = sclk;
            end
            cap[i] = txd;
         end
         wait_irq_tx();
         chk(cap == d, "R6", cap, d);
         chk(sclk == 1'b1 && irq_tx == 1'b1, "R6", {sclk, irq_tx}, 3);
         clr_flags();
      end

      // R9 receive
      set_ctl(2'd1, 1'b1, 1'b0);
      rx_check(8'h81, 1'b1, "R9");
      for (int k = 0; k < 2; k++) rx_check(8'($urandom), 1'b1, "R9");
      set_ctl(2'd3, 1'b1, 1'b0);
      rx_check(8'h4E, 1'b1, "R9");
      rx_check(8'($urandom), 1'b0, "R9");
      set_ctl(2'd2, 1'b1, 1'b0);
      rx_check(8'($urandom), 1'b1, "R9");

      // R10 glitch rejection
      set_ctl(2'd1, 1'b1, 1'b0);
      @(negedge clk);
      rxd = 1'b0;
      repeat (24) @(negedge clk);
      rxd = 1'b1;
      repeat (800) @(negedge clk);
      chk(irq_rx == 1'b0, "R10", irq_rx, 0);
      rx_check(8'h37, 1'b1, "R10");

      // R12 overrun
      a = 8'($urandom); b = ~a;
      send_rx(a, 1'b1);
      send_rx(b, 1'b1);
      rd(1'b1, v);
      chk(v == a, "R12", v, a);
      rd(1'b0, v);
      chk(v[7] == 1'b1 && v[6] == 1'b1, "R12", v[7:6], 3);
      clr_flags();

      // R11 double buffering
      a = 8'h6B; b = 8'hD4;
      send_rx(a, 1'b1);
      fork
         send_rx(b, 1'b1);
         begin
            repeat (192) @(negedge clk);
            rd(1'b1, v);
            chk(v == a, "R11", v, a);
            clr_flags();
         end
      join
      rd(1'b1, v);
      chk(v == b, "R11", v, b);
      rd(1'b0, v);
      chk(v[7] == 1'b0 && v[6] == 1'b1, "R11", v[7:6], 1);
      clr_flags();

      // R13 full duplex
      for (int k = 0; k < 2; k++) begin
         a = 8'($urandom); b = 8'($urandom);
         wr(1'b1, a);
         fork
            capture(got);
            send_rx(b, 1'b1);
         join
         chk(got == exp_frame(2'd1, a, 1'b0), "R13", got, exp_frame(2'd1, a, 1'b0));
         rd(1'b1, v);
         chk(v == b && irq_rx == 1'b1, "R13", v, b);
         clr_flags();
      end

      // R14 receiver disabled
      rd(1'b1, a);
      set_ctl(2'd1, 1'b0, 1'b0);
      send_rx(~a, 1'b1);
      chk(irq_rx == 1'b0, "R14", irq_rx, 0);
      rd(1'b1, v);
      chk(v == a, "R14", v, a);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule